// File: doc/BRIEF.md
# Timed Halt Wakeup Controller

This block lets a CPU stop its main clock and sleep for a programmed time, then restarts the clock safely. A slow auxiliary clock keeps running during the sleep. On that clock, a fixed divide-by-64 stage feeds a programmable divider of 1 to 255, and the pair sets the sleep length. When the time has elapsed, the block raises a wakeup flag and interrupt and turns the main oscillator back on. It holds the CPU clock off until a stabilization count has run out. That count is 256 or 4096 main cycles.

A halt request from the CPU starts the sequence. If the timed-wakeup enable is clear, the request gives an ordinary halt that only an external interrupt can end. Any external interrupt also ends a timed halt, and so does a pending wakeup flag. Both start the same restart sequence. When the watchdog is active and configured for it, a halt request causes a watchdog reset instead of a halt. A measurement bit sends the auxiliary clock to a timer capture pin while the CPU runs, so software can measure the clock and calibrate the divider value.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After reset, osc_en=1, cpu_clk_en=1, halted=0, wake_irq=0, wdg_rst=0 and imask_wr=0.
- R2: Register address 0 is control/status: bit 0 is timed-wakeup enable, bit 1 is measurement enable, and bit 2 is the wakeup flag (read-only). Address 1 is the 8-bit divider value. A read pulse on reg_rd returns the addressed value on reg_rdata one cycle later.
- R3: A halt request while running, with enable=1 and no watchdog trip, gives halted=1, osc_en=0 and cpu_clk_en=0 from the next cycle. In the same cycle, imask_wr pulses for one cycle with imask_val=2'b10.
- R4: A timed halt lasts 64*P auxiliary cycles plus a few cycles of synchronizer latency, where P is the divider value. P=0 acts as P=1.
- R5: When the interval expires, the wakeup flag sets, wake_irq goes to 1 and osc_en rises.
- R6: After osc_en rises on wakeup, cpu_clk_en stays 0 for exactly 256 main cycles when stab_sel=0, or 4096 when stab_sel=1.
- R7: A read of address 0 returns the flag as it was before the read, then clears the flag and wake_irq.
- R8: With enable=0, a halt request gives a plain halt. It has no timed wakeup and never sets the flag.
- R9: Any high ext_irq bit during a halt, or a wakeup flag still set, starts oscillator restart on the next cycle without setting the flag. A request pending at halt entry therefore exits after a single halted cycle.
- R10: A halt request with wdg_active=1 and wdg_halt_rst=1 gives a one-cycle wdg_rst pulse and no halt. With wdg_halt_rst=0 it halts normally.
- R11: meas_clk equals aux_clk while the measurement bit is set and the CPU runs, and is 0 otherwise.
- R12: The divider chain restarts at every halt entry, so a halt that an interrupt ends early does not shorten the next interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_clk | input | 1 | Free-running low-frequency auxiliary clock |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | Register select (0 control/status, 1 divider) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| halt_req | input | 1 | CPU halt request strobe |
| ext_irq | input | 4 | Enabled external interrupt requests |
| wdg_active | input | 1 | Watchdog is running |
| wdg_halt_rst | input | 1 | Configuration: halt with active watchdog resets |
| stab_sel | input | 1 | Stabilization length select (0: 256, 1: 4096) |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock release |
| halted | output | 1 | Block is not in the run state |
| wake_irq | output | 1 | Wakeup interrupt request (mirrors the flag) |
| imask_wr | output | 1 | One-cycle pulse forcing the CPU interrupt mask |
| imask_val | output | 2 | Mask value to force at halt entry |
| wdg_rst | output | 1 | Watchdog reset request pulse |
| meas_clk | output | 1 | Auxiliary clock routed to timer capture |

## Verification
The assertions check the following on every cycle: the halt-entry sequence and the mask pulse, interrupt-driven exit from either halt state, the watchdog trip, flag set and clear around reads, the wakeup pulse being one cycle wide, and the expired state holding until timing stops. Only the bench scenarios can show that the interval length scales with the divider value, including zero, and that the two stabilization lengths are exact. They also show that a plain halt never wakes on its own, that an interrupted halt leaves the next interval at full length, and that the measurement clock follows the auxiliary clock only while running.

// File: rtl/awu_pkg.sv
package awu_pkg;
  typedef enum logic [1:0] {
    ST_RUN        = 2'd0,
    ST_HALT_PLAIN = 2'd1,
    ST_HALT_TIMED = 2'd2,
    ST_OSC_START  = 2'd3
  } awu_state_e;

  localparam int CSR_EN_BIT   = 0;
  localparam int CSR_MEAS_BIT = 1;
  localparam int CSR_FLAG_BIT = 2;
  localparam logic ADDR_CSR   = 1'b0;
  localparam logic ADDR_PRESC = 1'b1;
  localparam logic [1:0] IMASK_HALT = 2'b10;
endpackage

// File: rtl/awu_aux_div.sv
module awu_aux_div #(
  parameter int FIX_DIV = 64,
  parameter int PW      = 8
) (
  input  logic          aux_clk,
  input  logic          rst,
  input  logic          run_req,
  input  logic [PW-1:0] presc,
  output logic          expired
);
  localparam int FW = $clog2(FIX_DIV);

  logic [1:0]    run_sync;
  logic [FW-1:0] fix_cnt;
  logic [PW-1:0] pre_cnt;
  logic [PW-1:0] presc_eff;

  assign presc_eff = (presc == '0) ? PW'(1) : presc;

  always_ff @(posedge aux_clk) begin
    if (rst) run_sync <= '0;
    else     run_sync <= {run_sync[0], run_req};
  end

  // chain is held cleared whenever timing is not requested
  always_ff @(posedge aux_clk) begin
    if (rst || !run_sync[1]) begin
      fix_cnt <= '0;
      pre_cnt <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (fix_cnt == FW'(FIX_DIV - 1)) begin
        fix_cnt <= '0;
        if (pre_cnt == presc_eff - PW'(1)) begin
          pre_cnt <= '0;
          expired <= 1'b1;
        end else begin
          pre_cnt <= pre_cnt + PW'(1);
        end
      end else begin
        fix_cnt <= fix_cnt + FW'(1);
      end
    end
  end

  assert_expire_hold_R5: assert property (@(posedge aux_clk) disable iff (rst)
    $fell(expired) |-> !$past(run_sync[1]));
endmodule

// File: rtl/awu_sync_rise.sv
module awu_sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic pulse
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      pulse <= 1'b0;
    end else begin
      sh    <= {sh[STAGES-1:0], d};
      pulse <= sh[STAGES-1] & ~sh[STAGES];
    end
  end

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/awu_csr.sv
module awu_csr
  import awu_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic          addr,
  input  logic [PW-1:0] wdata,
  input  logic          wake_set,
  output logic [PW-1:0] rdata,
  output logic          en,
  output logic          meas,
  output logic          flag,
  output logic [PW-1:0] presc
);
  logic [PW-1:0] csr_view;

  always_comb begin
    csr_view = '0;
    csr_view[CSR_EN_BIT]   = en;
    csr_view[CSR_MEAS_BIT] = meas;
    csr_view[CSR_FLAG_BIT] = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= 1'b0;
      meas  <= 1'b0;
      flag  <= 1'b0;
      presc <= '0;
      rdata <= '0;
    end else begin
      if (wr && addr == ADDR_CSR) begin
        en   <= wdata[CSR_EN_BIT];
        meas <= wdata[CSR_MEAS_BIT];
      end
      if (wr && addr == ADDR_PRESC) presc <= wdata;
      if (rd) rdata <= (addr == ADDR_PRESC) ? presc : csr_view;
      if (wake_set)                     flag <= 1'b1;
      else if (rd && addr == ADDR_CSR)  flag <= 1'b0;
    end
  end

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == ADDR_CSR && !wake_set) |=> !flag);
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
    wake_set |=> flag);
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import awu_pkg::*;
#(
  parameter int PW         = 8,
  parameter int N_IRQ      = 4,
  parameter int FIX_DIV    = 64,
  parameter int STAB_SHORT = 256,
  parameter int STAB_LONG  = 4096,
  parameter int SYNC_STG   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             aux_clk,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_addr,
  input  logic [PW-1:0]    reg_wdata,
  output logic [PW-1:0]    reg_rdata,
  input  logic             halt_req,
  input  logic [N_IRQ-1:0] ext_irq,
  input  logic             wdg_active,
  input  logic             wdg_halt_rst,
  input  logic             stab_sel,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic             halted,
  output logic             wake_irq,
  output logic             imask_wr,
  output logic [1:0]       imask_val,
  output logic             wdg_rst,
  output logic             meas_clk
);
  localparam int SW = $clog2(STAB_LONG + 1);
  localparam logic [SW-1:0] LAST_S = SW'(STAB_SHORT - 1);
  localparam logic [SW-1:0] LAST_L = SW'(STAB_LONG - 1);

  awu_state_e    state_q, st_d;
  logic [SW-1:0] stab_cnt;
  logic [SW-1:0] stab_last;
  logic          en, meas, flag;
  logic [PW-1:0] presc;
  logic          aux_expired, wake_pulse;
  logic          any_irq, wdg_trip, run_timed;

  assign any_irq   = |ext_irq;
  assign wdg_trip  = wdg_active & wdg_halt_rst;
  assign stab_last = stab_sel ? LAST_L : LAST_S;
  assign run_timed = (state_q == ST_HALT_TIMED);
  assign wake_irq  = flag;
  assign imask_val = IMASK_HALT;
  assign meas_clk  = aux_clk & meas & cpu_clk_en;

  awu_csr #(.PW(PW)) u_csr (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .wake_set(wake_pulse), .rdata(reg_rdata),
    .en(en), .meas(meas), .flag(flag), .presc(presc)
  );

  awu_aux_div #(.FIX_DIV(FIX_DIV), .PW(PW)) u_div (
    .aux_clk(aux_clk), .rst(rst), .run_req(run_timed),
    .presc(presc), .expired(aux_expired)
  );

  awu_sync_rise #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d(aux_expired), .pulse(wake_pulse)
  );

  always_comb begin
    st_d = state_q;
    case (state_q)
      ST_RUN:        if (halt_req && !wdg_trip)
                       st_d = en ? ST_HALT_TIMED : ST_HALT_PLAIN;
      ST_HALT_PLAIN: if (any_irq || flag) st_d = ST_OSC_START;
      ST_HALT_TIMED: if (any_irq || flag || wake_pulse) st_d = ST_OSC_START;
      ST_OSC_START:  if (stab_cnt == stab_last) st_d = ST_RUN;
      default:       st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      osc_en     <= 1'b1;
      cpu_clk_en <= 1'b1;
      halted     <= 1'b0;
      imask_wr   <= 1'b0;
      wdg_rst    <= 1'b0;
    end else begin
      state_q    <= st_d;
      osc_en     <= (st_d == ST_RUN) || (st_d == ST_OSC_START);
      cpu_clk_en <= (st_d == ST_RUN);
      halted     <= (st_d != ST_RUN);
      imask_wr   <= (state_q == ST_RUN) && halt_req && !wdg_trip;
      wdg_rst    <= (state_q == ST_RUN) && halt_req && wdg_trip;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || state_q != ST_OSC_START) stab_cnt <= '0;
    else                                stab_cnt <= stab_cnt + SW'(1);
  end

  assert_halt_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && halt_req && !wdg_trip) |=> (halted && !osc_en && imask_wr));
  assert_irq_exit_R9: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_HALT_PLAIN || state_q == ST_HALT_TIMED) && any_irq)
      |=> (osc_en && !cpu_clk_en));
  assert_wdg_no_halt_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && halt_req && wdg_trip) |=> (wdg_rst && !halted));
  assert_release_after_osc_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_clk_en) |-> $past(osc_en));
  assert_meas_gate_R11: assert property (@(posedge clk) disable iff (rst)
    !cpu_clk_en |-> !meas_clk);
endmodule

// File: tb/sim_halt_wake_ctrl.sv
`timescale 1ns/1ps
module sim_halt_wake_ctrl;
  logic clk = 0, aux_clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic halt_req = 0;
  logic [3:0] ext_irq = 0;
  logic wdg_active = 0, wdg_halt_rst = 0, stab_sel = 0;
  logic osc_en, cpu_clk_en, halted, wake_irq, imask_wr, wdg_rst, meas_clk;
  logic [1:0] imask_val;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always #20 aux_clk = ~aux_clk;

  halt_wake_ctrl u0 (
    .clk(clk), .rst(rst), .aux_clk(aux_clk), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .halt_req(halt_req), .ext_irq(ext_irq), .wdg_active(wdg_active),
    .wdg_halt_rst(wdg_halt_rst), .stab_sel(stab_sel), .osc_en(osc_en),
    .cpu_clk_en(cpu_clk_en), .halted(halted), .wake_irq(wake_irq),
    .imask_wr(imask_wr), .imask_val(imask_val), .wdg_rst(wdg_rst),
    .meas_clk(meas_clk)
  );

  // expected interval in main cycles: 64 aux cycles per step, aux = 8 main
  function automatic int exp_interval(input int p);
    int e = (p == 0) ? 1 : p;
    return 64 * e * 8;
  endfunction
  function automatic int exp_stab(input bit sel);
    return sel ? 4096 : 256;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic csr_rd(input logic a, output logic [7:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk); d = reg_rdata; reg_rd = 0;
  endtask
  task automatic do_halt();
    halt_req = 1; @(negedge clk); halt_req = 0;
  endtask
  task automatic pulse_irq();
    ext_irq = 4'b0100; @(negedge clk); ext_irq = 0;
  endtask
  task automatic wait_run();
    while (!cpu_clk_en) @(negedge clk);
  endtask
  task automatic wait_osc(output int n);
    n = 0;
    while (!osc_en && n < 150000) begin @(negedge clk); n++; end
  endtask

  task automatic run_timed(input int p, input bit sel, input string tag);
    int n; logic [7:0] d; int e;
    stab_sel = sel;
    csr_wr(1'b1, p[7:0]);
    csr_wr(1'b0, 8'h01);
    do_halt();
    chk(halted && !osc_en && !cpu_clk_en, {"R3 halted ", tag}, halted, 1);
    chk(imask_wr && imask_val == 2'b10, {"R3 imask ", tag}, imask_val, 2);
    wait_osc(n);
    e = exp_interval(p);
    chk(n >= e && n <= e + 48, {"R4 interval ", tag}, n, e);
    chk(wake_irq == 1, {"R5 flag ", tag}, wake_irq, 1);
    n = 0;
    while (osc_en && !cpu_clk_en) begin n++; @(negedge clk); end
    chk(n == exp_stab(sel), {"R6 stab ", tag}, n, exp_stab(sel));
    csr_rd(1'b0, d);
    chk(d[2] == 1, {"R7 read shows flag ", tag}, d[2], 1);
    chk(wake_irq == 0, {"R7 cleared ", tag}, wake_irq, 0);
  endtask

  initial begin
    forever begin
      @(negedge clk); cyc++;
      if (cyc > 190000 && !done) begin
        done = 1; fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    void'($urandom(32'd2024));
    repeat (100) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(osc_en && cpu_clk_en && !halted && !wake_irq && !wdg_rst && !imask_wr,
        "R1 reset outputs", {osc_en, cpu_clk_en, halted, wake_irq}, 4'b1100);
    // R2
    csr_wr(1'b1, 8'hA5); csr_rd(1'b1, d);
    chk(d == 8'hA5, "R2 divider readback", d, 8'hA5);
    csr_wr(1'b0, 8'hFF); csr_rd(1'b0, d);
    chk(d == 8'h03, "R2 csr readback", d, 8'h03);
    csr_wr(1'b0, 8'h00);
    // directed timed halts
    run_timed(3, 1'b0, "p3");
    csr_rd(1'b0, d);
    chk(d[2] == 0, "R7 second read", d[2], 0);
    run_timed(0, 1'b1, "p0 as 1");
    // random intervals
    for (int i = 0; i < 5; i++) begin
      run_timed($urandom_range(0, 5), 1'($urandom_range(0, 1)), "random");
    end
    // R8 plain halt
    csr_wr(1'b0, 8'h00); csr_wr(1'b1, 8'h01);
    do_halt();
    chk(halted && !osc_en, "R8 plain halt entered", halted, 1);
    n = 0;
    repeat (3000) begin @(negedge clk); if (osc_en) n++; end
    chk(n == 0, "R8 no timed wake", n, 0);
    pulse_irq();
    chk(osc_en && !cpu_clk_en, "R9 irq ends plain halt", osc_en, 1);
    wait_run();
    csr_rd(1'b0, d);
    chk(d[2] == 0, "R8 flag untouched", d[2], 0);
    // R9 + R12: interrupted timed halt, then full interval
    stab_sel = 0;
    csr_wr(1'b1, 8'd8); csr_wr(1'b0, 8'h01);
    do_halt();
    repeat (1000) @(negedge clk);
    chk(!osc_en, "R9 still halted", osc_en, 0);
    pulse_irq();
    chk(osc_en, "R9 irq ends timed halt", osc_en, 1);
    wait_run();
    csr_rd(1'b0, d);
    chk(d[2] == 0, "R9 no flag on irq exit", d[2], 0);
    do_halt();
    wait_osc(n);
    chk(n >= exp_interval(8) && n <= exp_interval(8) + 48, "R12 full interval", n, exp_interval(8));
    wait_run();
    csr_rd(1'b0, d);
    // R9 pending irq at entry
    ext_irq = 4'b0001;
    do_halt();
    chk(halted, "R9 pending irq enters", halted, 1);
    @(negedge clk);
    chk(osc_en, "R9 pending irq exits", osc_en, 1);
    ext_irq = 0;
    wait_run();
    // R9 pending flag at entry
    csr_wr(1'b1, 8'd1);
    do_halt(); wait_osc(n); wait_run();
    do_halt();
    chk(halted, "R9 flag pending enters", halted, 1);
    @(negedge clk);
    chk(osc_en, "R9 flag pending exits", osc_en, 1);
    wait_run();
    csr_rd(1'b0, d);
    // R10 watchdog
    csr_wr(1'b0, 8'h00);
    wdg_active = 1; wdg_halt_rst = 1;
    do_halt();
    chk(wdg_rst && !halted, "R10 watchdog reset", {wdg_rst, halted}, 2);
    @(negedge clk);
    chk(!wdg_rst && !halted, "R10 pulse ends", {wdg_rst, halted}, 0);
    wdg_halt_rst = 0;
    do_halt();
    chk(halted && !wdg_rst, "R10 halt when not configured", halted, 1);
    pulse_irq(); wait_run();
    wdg_active = 0;
    // R11 measurement
    csr_wr(1'b0, 8'h02);
    n = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); #1;
      if (meas_clk != aux_clk) n++;
    end
    chk(n == 0, "R11 follows aux", n, 0);
    @(negedge clk);
    do_halt();
    n = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); #1;
      if (meas_clk) n++;
    end
    chk(n == 0, "R11 off in halt", n, 0);
    @(negedge clk);
    pulse_irq(); wait_run();
    csr_wr(1'b0, 8'h00);
    n = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); #1;
      if (meas_clk) n++;
    end
    chk(n == 0, "R11 off when bit clear", n, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule